// File: doc/BRIEF.md
# Center-Aligned Three-Phase PWM Generator

This block produces three center-aligned pulse-width waves from a single triangular carrier. A 16-bit counter runs up from 1 to a programmed peak and back down to 1. Each phase compares the counter against its own width value and drives its output active while the count is at or above that value. Because all three phases share one carrier, their pulses stay centered on the same carrier valley. Motor-drive logic downstream can add dead time and complementary legs.

The counter pauses for two extra clocks at each turning point, so one carrier period lasts exactly 2·(m+1) clocks for a peak value m. A crest pulse marks the top turn and a valley pulse marks the bottom turn. New peak and width values take effect only at a crest, so a period that has started always finishes with the values it began with. While the enable is low the block idles: the counter is parked at 1, counting up, all phases are inactive, and the working copies follow the inputs. None of the pins carries streamed data. Every input is a plain level sampled on the clock and there is no back-pressure.

Top module: `cpwm3_core`

## Requirements
- R1: While `rst` is high, and on every clock after `en` was sampled low, `cnt_out` is 1, `cnt_up` is 1 (1 = counting up, 0 = counting down), all `phase_out` bits are 0 and `crest_pls` and `valley_pls` are 0.
- R2: On the first clock edge with `en` high after idling, the counter shows 1 counting up. It then rises by one each clock.
- R3: When the count equals the peak m while counting up, `crest_pls` is high for that one clock. The count then stays at m for two more clocks with `cnt_up` = 0, and after that it decrements by one per clock.
- R4: When the count equals 1 while counting down, `valley_pls` is high for that one clock. The count then stays at 1 for two more clocks with `cnt_up` = 1, and after that it increments again. One full carrier period is 2·(m+1) clocks, and the smallest peak value is 2.
- R5: Phase i (bits `duty_val[i*16 +: 16]`, i = 0 for U, 1 for V, 2 for W) drives `phase_out[i]` high exactly when the running count is greater than or equal to its width value.
- R6: A width of 0 keeps its phase high for the whole run. A width of m+1 keeps it low for the whole run.
- R7: Changes on `cyc_val` and `duty_val` made while running have no effect until the crest. From the clock after the crest, the new widths are used, and the new peak governs the next rise.
- R8: `crest_pls` and `valley_pls` are each high for single clocks only and are never high together.
- R9: Dropping `en` in the middle of a period returns the counter and outputs to the idle state of R1 on the next clock.
- R10: The three phases work independently: each follows only its own width value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low parks the carrier |
| cyc_val | input | 16 | Carrier peak m (2 to FFFEh) |
| duty_val | input | 48 | Three width values, phase i in bits [i*16 +: 16] |
| phase_out | output | 3 | Phase levels, bit 0 = U, 1 = V, 2 = W |
| cnt_out | output | 16 | Carrier count |
| cnt_up | output | 1 | Count direction, 1 = up |
| crest_pls | output | 1 | One-clock pulse at the top turn |
| valley_pls | output | 1 | One-clock pulse at the bottom turn |

## Verification
The bench builds the block with its default parameters: a 16-bit carrier and three phases. It uses small peak values down to the minimum of 2, so each run covers many complete carrier periods within a few hundred clocks, including both turning-point dwells. With such short periods the width extremes 0, m and m+1 can be exercised on every phase. A width and peak change made mid-period can also be followed through its crest into the next period with a different length.

// File: rtl/cpwm3_pkg.sv
package cpwm3_pkg;
  typedef enum logic {
    CNT_DOWN = 1'b0,
    CNT_UP   = 1'b1
  } cnt_dir_e;
endpackage

// File: rtl/cpwm3_carrier.sv
module cpwm3_carrier
  import cpwm3_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] cyc_in,
  output logic          ld_o,
  output logic          run_o,
  output logic [CW-1:0] cnt_o,
  output logic          up_o,
  output logic          crest_o,
  output logic          valley_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] peak_q;
  cnt_dir_e      dir_q;
  logic          hold_q;
  logic          run_q;
  logic          crest;
  logic          valley;

  // turning points are only recognised on a non-dwell tick
  assign crest  = run_q && !hold_q && (dir_q == CNT_UP)   && (cnt_q >= peak_q);
  assign valley = run_q && !hold_q && (dir_q == CNT_DOWN) && (cnt_q <= ONE);

  // working copies reload while parked, at start, and at each crest
  assign ld_o = rst || !en || !run_q || crest;

  always_ff @(posedge clk) begin
    if (ld_o) peak_q <= cyc_in;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q  <= ONE;
      dir_q  <= CNT_UP;
      hold_q <= 1'b0;
      run_q  <= 1'b0;
    end else if (!run_q) begin
      run_q <= 1'b1;
    end else if (hold_q) begin
      hold_q <= 1'b0;
    end else if (dir_q == CNT_UP) begin
      if (crest) begin
        dir_q  <= CNT_DOWN;
        hold_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end else begin
      if (valley) begin
        dir_q  <= CNT_UP;
        hold_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  assign run_o    = run_q;
  assign cnt_o    = cnt_q;
  assign up_o     = (dir_q == CNT_UP);
  assign crest_o  = crest;
  assign valley_o = valley;

  // R1
  idle_park_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt_q == ONE && dir_q == CNT_UP && !run_q));

  // R2
  rise_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && run_q && !hold_q && dir_q == CNT_UP && !crest) |=> (cnt_q == $past(cnt_q) + ONE));

  // R3
  crest_turn_chk: assert property (@(posedge clk) disable iff (rst)
    (en && crest) |=> (dir_q == CNT_DOWN && $stable(cnt_q) && hold_q));

  // R4
  valley_turn_chk: assert property (@(posedge clk) disable iff (rst)
    (en && valley) |=> (dir_q == CNT_UP && cnt_q == ONE && hold_q));

  // R8
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(crest && valley));

  // R8
  crest_single_chk: assert property (@(posedge clk) disable iff (rst)
    crest |=> !crest);
endmodule

// File: rtl/cpwm3_phase.sv
module cpwm3_phase #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_i,
  input  logic          run_i,
  input  logic [CW-1:0] duty_in,
  input  logic [CW-1:0] cnt_i,
  output logic          phase_o
);
  logic [CW-1:0] duty_q;

  always_ff @(posedge clk) begin
    if (ld_i) duty_q <= duty_in;
  end

  assign phase_o = run_i && (cnt_i >= duty_q);

  // R7
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run_i && $past(run_i) && $stable(cnt_i) && !$past(ld_i)) |-> $stable(phase_o));

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run_i |-> !phase_o);
endmodule

// File: rtl/cpwm3_core.sv
module cpwm3_core #(
  parameter int CW  = 16,
  parameter int NPH = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [CW-1:0]   cyc_val,
  input  logic [NPH*CW-1:0] duty_val,
  output logic [NPH-1:0]  phase_out,
  output logic [CW-1:0]   cnt_out,
  output logic            cnt_up,
  output logic            crest_pls,
  output logic            valley_pls
);
  logic          ld;
  logic          run;
  logic [CW-1:0] cnt;

  cpwm3_carrier #(.CW(CW)) u_carrier (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .cyc_in   (cyc_val),
    .ld_o     (ld),
    .run_o    (run),
    .cnt_o    (cnt),
    .up_o     (cnt_up),
    .crest_o  (crest_pls),
    .valley_o (valley_pls)
  );

  for (genvar i = 0; i < NPH; i++) begin : g_ph
    cpwm3_phase #(.CW(CW)) u_phase (
      .clk     (clk),
      .rst     (rst),
      .ld_i    (ld),
      .run_i   (run),
      .duty_in (duty_val[i*CW +: CW]),
      .cnt_i   (cnt),
      .phase_o (phase_out[i])
    );
  end

  assign cnt_out = cnt;

  // R10
  zero_width_chk: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !$past(ld) && $past(duty_val[0 +: CW]) == '0 && $stable(duty_val[0 +: CW]))
      |-> phase_out[0]);
endmodule

// File: tb/tb_cpwm3_core.sv
module tb_cpwm3_core;
  localparam int CW  = 16;
  localparam int NPH = 3;

  typedef struct {
    int    cnt;
    bit    up;
    bit [2:0] ph;
    bit    cr;
    bit    va;
    string tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              en  = 1'b0;
  logic [CW-1:0]     cyc_val = 16'd5;
  logic [NPH*CW-1:0] duty_val = '0;
  logic [NPH-1:0]    phase_out;
  logic [CW-1:0]     cnt_out;
  logic              cnt_up;
  logic              crest_pls;
  logic              valley_pls;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  cpwm3_core #(.CW(CW), .NPH(NPH)) dut (
    .clk(clk), .rst(rst), .en(en), .cyc_val(cyc_val), .duty_val(duty_val),
    .phase_out(phase_out), .cnt_out(cnt_out), .cnt_up(cnt_up),
    .crest_pls(crest_pls), .valley_pls(valley_pls)
  );

  function automatic int tri_cnt(int p, int m);
    if (p < m) return p + 1;
    if (p <= 2*m) return ((2*m + 1 - p) > m) ? m : (2*m + 1 - p);
    return 1;
  endfunction

  function automatic bit tri_up(int p, int m);
    return (p < m) || (p == 2*m + 1);
  endfunction

  task automatic push_idle(int n, string tag);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e.cnt = 1; e.up = 1; e.ph = 3'b000; e.cr = 0; e.va = 0; e.tag = tag;
      sb.push_back(e);
    end
  endtask

  task automatic idle(int n, string tag);
    @(negedge clk);
    en = 1'b0;
    push_idle(n, tag);
    repeat (n) @(negedge clk);
  endtask

  // runs from idle; inputs switch to (m2,d2) after tick chg_at (chg_at+1 < m1)
  task automatic run_seg(int m1, int d1[3], int m2, int d2[3], int chg_at, int n, string tag);
    @(negedge clk);
    en = 1'b1;
    cyc_val = CW'(m1);
    for (int i = 0; i < 3; i++) duty_val[i*CW +: CW] = CW'(d1[i]);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      int p, m, c;
      if (k < 2*m1 + 2) begin p = k; m = m1; end
      else begin p = (k - 2*m1 - 2) % (2*m2 + 2); m = m2; end
      c = tri_cnt(p, m);
      e.cnt = c;
      e.up  = tri_up(p, m);
      for (int i = 0; i < 3; i++) e.ph[i] = (c >= ((k < m1) ? d1[i] : d2[i]));
      e.cr  = (p == m - 1);
      e.va  = (p == 2*m);
      e.tag = tag;
      sb.push_back(e);
    end
    repeat (chg_at + 1) @(negedge clk);
    cyc_val = CW'(m2);
    for (int i = 0; i < 3; i++) duty_val[i*CW +: CW] = CW'(d2[i]);
    repeat (n - chg_at - 1) @(negedge clk);
  endtask

  // monitor: sample shortly after each rising edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (int'(cnt_out) != e.cnt || cnt_up != e.up || phase_out != e.ph ||
          crest_pls != e.cr || valley_pls != e.va) begin
        errors++;
        $display("FAIL %s: cnt=%0d up=%0b ph=%b cr=%0b va=%0b expected cnt=%0d up=%0b ph=%b cr=%0b va=%0b",
                 e.tag, cnt_out, cnt_up, phase_out, crest_pls, valley_pls,
                 e.cnt, e.up, e.ph, e.cr, e.va);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int da[3], db[3];
    // R1 reset state
    push_idle(4, "R1 reset");
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(3, "R1 idle");

    // R2 R3 R4 R5: m=5, widths in range; R6: width 0 and m+1
    da = '{0, 3, 6};
    run_seg(5, da, 5, da, 0, 40, "R2 R3 R4 R5 R6 R8");
    idle(3, "R9 after run");

    // R4 minimum peak, widths 1, m, m+1 (R10 independent phases)
    da = '{1, 2, 3};
    run_seg(2, da, 2, da, 0, 20, "R4 R6 R10 min peak");
    idle(2, "R1 park");

    // R7 mid-period change of widths and peak, honoured only after the crest
    da = '{2, 4, 7};
    db = '{5, 0, 3};
    run_seg(6, da, 4, db, 2, 34, "R7 crest latch");
    idle(2, "R9 drop");

    // R9 drop enable mid-rise
    da = '{9, 10, 1};
    run_seg(9, da, 9, da, 0, 6, "R5 R10 partial");
    idle(3, "R9 mid-rise drop");

    // R5 R6 longer run with width equal to peak
    da = '{9, 10, 0};
    run_seg(9, da, 9, da, 0, 45, "R3 R4 R5 R6");
    idle(2, "R1 end");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule